// File: doc/BRIEF.md
# Block-Granular Security Gate

This block sits in front of a memory and decides, access by access, whether a request may reach it. The protected window is cut into equal power-of-two blocks. Each block owns one bit in a packed lookup table: a 1 lets non-secure traffic through, a 0 reserves the block for secure traffic. Secure requests always pass. A non-secure request that lands on a secure block is denied.

Software programs the gate through a small 32-bit register port. The port holds a control word with two reporting enables, a read-only configuration word, and the table words. The configuration word reports the block size and the block count, both taken from module parameters. The allow/deny decision is registered, so the forwarded request or the denial appears one clock after the request is presented. A denial can complete with an error response or silently, with zero read data and a dropped write. A denial can also raise a one-cycle fault pulse.

Top module: `blk_sec_gate`

## Requirements
- R1: After reset, every table bit and both control bits are 0, and `fwd_valid`, `deny_valid`, `deny_err` and `fault` are low.
- R2: The word at byte offset 0x04 reads as bit 31 = 1, bits [11:8] = COUNT_CODE and bits [3:0] = SIZE_CODE, with all other bits 0. Writes to it change nothing.
- R3: Bits [1:0] of the word at offset 0x00 can be written and read back. Its other bits read 0.
- R4: The table word at offset 0x10 + 4*k holds block 32*k + b in bit b, and it reads back what was written to it. A register read returns its data on `reg_rdata` one cycle after `reg_rd`.
- R5: The block index of a request is its window offset divided by 2^(SIZE_CODE+5) bytes. Every byte of one block shares that block's bit.
- R6: One cycle after a request, exactly one of `fwd_valid` and `deny_valid` is high. A secure request (`acc_nsec` = 0) is always forwarded. A non-secure request is forwarded only when its block's bit is 1. Address, direction, data and attribute are passed through unchanged.
- R7: On a denial, `deny_err` equals control bit 1. With that bit clear, the denial completes without error: the read data is zero and `fwd_valid` stays low, so a write is dropped.
- R8: When control bit 0 is set, each denial drives `fault` high for exactly one cycle. When the bit is clear, `fault` stays low.
- R9: Blocks at or beyond 2^COUNT_CODE have no storage. Their table words read 0 and ignore writes, and a non-secure request to such a block is denied.
- R10: Writes to offsets 0x08 and 0x0C, and to any offset past the last implemented table word, are ignored. Reads from these offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| acc_valid | input | 1 | Access request present |
| acc_ofs | input | OFS_W | Byte offset of the access into the window |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_nsec | input | 1 | 1 = non-secure access |
| acc_wdata | input | 32 | Write data of the access |
| fwd_valid | output | 1 | Allowed access forwarded to memory |
| fwd_ofs | output | OFS_W | Forwarded offset |
| fwd_write | output | 1 | Forwarded direction |
| fwd_nsec | output | 1 | Forwarded attribute |
| fwd_wdata | output | 32 | Forwarded write data |
| deny_valid | output | 1 | Access denied this cycle |
| deny_err | output | 1 | Denial completes with an error response |
| fault | output | 1 | One-cycle fault pulse per denial |

## Verification
The hardest situation to reach is a non-secure request to a block whose bit sits next to differently valued bits, and in particular the first and last bytes of a block at a word seam. That case exposes any error in the index shift and in the word/bit split. The bench writes an arithmetic stripe pattern that is not periodic in 32 into both table words. It then sweeps every block at its lowest and highest byte with both attributes, and continues past the last block. The four control settings are then cycled over one denied read and one denied write to cover every response combination.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;
  localparam int CTRL_WIDX     = 0;
  localparam int CFG_WIDX      = 1;
  localparam int LUT_BASE_WIDX = 4;
  localparam int LUT_MAX_WORDS = 15;
  localparam int MIN_SHIFT     = 5;

  // bits of table word w that map to an existing block
  function automatic logic [31:0] word_mask(input int w, input int blk_cnt);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((w * 32 + b) < blk_cnt);
    return m;
  endfunction
endpackage

// File: rtl/sec_gate_regs.sv
module sec_gate_regs
  import sec_gate_pkg::*;
#(
  parameter int SIZE_CODE  = 1,
  parameter int COUNT_CODE = 6,
  parameter int BLK_CNT    = 64,
  parameter int NWORDS     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [7:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [1:0]             ctrl_q,
  output logic [NWORDS*32-1:0]   lut_bits
);
  localparam logic [31:0] CFG_VAL = {1'b1, 19'd0, 4'(COUNT_CODE), 4'd0, 4'(SIZE_CODE)};

  logic [5:0]  widx;
  logic [31:0] lut_w [NWORDS];
  logic [31:0] rd_val;
  logic        unused_bits;

  assign widx        = reg_addr[7:2];
  assign unused_bits = ^{reg_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst)                                     ctrl_q <= 2'b00;
    else if (reg_wr && widx == 6'(CTRL_WIDX))    ctrl_q <= reg_wdata[1:0];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [31:0] MASK = word_mask(w, BLK_CNT);
    always_ff @(posedge clk) begin
      if (rst)                                          lut_w[w] <= '0;
      else if (reg_wr && widx == 6'(LUT_BASE_WIDX + w)) lut_w[w] <= reg_wdata & MASK;
    end
    assign lut_bits[w*32 +: 32] = lut_w[w];
  end

  always_comb begin
    rd_val = '0;
    if (widx == 6'(CTRL_WIDX)) rd_val = {30'd0, ctrl_q};
    if (widx == 6'(CFG_WIDX))  rd_val = CFG_VAL;
    for (int w = 0; w < NWORDS; w++)
      if (widx == 6'(LUT_BASE_WIDX + w)) rd_val = lut_w[w];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/sec_gate_decide.sv
module sec_gate_decide
  import sec_gate_pkg::*;
#(
  parameter int SIZE_CODE = 1,
  parameter int BLK_CNT   = 64,
  parameter int NWORDS    = 2,
  parameter int OFS_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic [OFS_W-1:0]     acc_ofs,
  input  logic                 acc_write,
  input  logic                 acc_nsec,
  input  logic [31:0]          acc_wdata,
  input  logic [1:0]           ctrl_q,
  input  logic [NWORDS*32-1:0] lut_bits,
  output logic                 fwd_valid,
  output logic [OFS_W-1:0]     fwd_ofs,
  output logic                 fwd_write,
  output logic                 fwd_nsec,
  output logic [31:0]          fwd_wdata,
  output logic                 deny_valid,
  output logic                 deny_err,
  output logic                 fault
);
  localparam int SHIFT = SIZE_CODE + MIN_SHIFT;
  localparam int IDX_W = $clog2(NWORDS * 32);

  logic [OFS_W-1:0] blk_idx;
  logic             in_range;
  logic             ns_ok;
  logic             deny;

  assign blk_idx  = acc_ofs >> SHIFT;
  assign in_range = (blk_idx < OFS_W'(BLK_CNT));
  assign ns_ok    = in_range & lut_bits[blk_idx[IDX_W-1:0]];
  assign deny     = acc_valid & acc_nsec & ~ns_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid  <= 1'b0;
      deny_valid <= 1'b0;
      deny_err   <= 1'b0;
      fault      <= 1'b0;
      fwd_ofs    <= '0;
      fwd_write  <= 1'b0;
      fwd_nsec   <= 1'b0;
      fwd_wdata  <= '0;
    end else begin
      fwd_valid  <= acc_valid & ~deny;
      deny_valid <= deny;
      deny_err   <= deny & ctrl_q[1];
      fault      <= deny & ctrl_q[0];
      if (acc_valid) begin
        fwd_ofs   <= acc_ofs;
        fwd_write <= acc_write;
        fwd_nsec  <= acc_nsec;
        fwd_wdata <= acc_wdata;
      end
    end
  end
endmodule

// File: rtl/blk_sec_gate.sv
module blk_sec_gate
  import sec_gate_pkg::*;
#(
  parameter int SIZE_CODE  = 1,
  parameter int COUNT_CODE = 6,
  parameter int OFS_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             acc_valid,
  input  logic [OFS_W-1:0] acc_ofs,
  input  logic             acc_write,
  input  logic             acc_nsec,
  input  logic [31:0]      acc_wdata,
  output logic             fwd_valid,
  output logic [OFS_W-1:0] fwd_ofs,
  output logic             fwd_write,
  output logic             fwd_nsec,
  output logic [31:0]      fwd_wdata,
  output logic             deny_valid,
  output logic             deny_err,
  output logic             fault
);
  localparam int BLK_CNT = 1 << COUNT_CODE;
  localparam int NWORDS  = (BLK_CNT + 31) / 32;

  logic [1:0]           ctrl_q;
  logic [NWORDS*32-1:0] lut_bits;

  sec_gate_regs #(
    .SIZE_CODE(SIZE_CODE), .COUNT_CODE(COUNT_CODE),
    .BLK_CNT(BLK_CNT), .NWORDS(NWORDS)
  ) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl_q(ctrl_q), .lut_bits(lut_bits)
  );

  sec_gate_decide #(
    .SIZE_CODE(SIZE_CODE), .BLK_CNT(BLK_CNT), .NWORDS(NWORDS), .OFS_W(OFS_W)
  ) decide_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ofs(acc_ofs),
    .acc_write(acc_write), .acc_nsec(acc_nsec), .acc_wdata(acc_wdata),
    .ctrl_q(ctrl_q), .lut_bits(lut_bits),
    .fwd_valid(fwd_valid), .fwd_ofs(fwd_ofs), .fwd_write(fwd_write),
    .fwd_nsec(fwd_nsec), .fwd_wdata(fwd_wdata),
    .deny_valid(deny_valid), .deny_err(deny_err), .fault(fault)
  );
endmodule

// File: rtl/blk_sec_gate_chk.sv
module blk_sec_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic       acc_valid,
  input logic       acc_nsec,
  input logic [1:0] ctrl_q,
  input logic       fwd_valid,
  input logic       deny_valid,
  input logic       deny_err,
  input logic       fault
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!fwd_valid && !deny_valid && !deny_err && !fault));

  assert_cfg_present_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 8'h04) |=> reg_rdata[31]);

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (fwd_valid ^ deny_valid));

  assert_no_outcome_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!fwd_valid && !deny_valid));

  assert_secure_passes_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_nsec) |=> fwd_valid);

  assert_err_follows_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_nsec) |=> (!deny_valid || (deny_err == $past(ctrl_q[1]))));

  assert_err_needs_deny_R7: assert property (@(posedge clk) disable iff (rst)
    deny_err |-> deny_valid);

  assert_fault_follows_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_nsec) |=> (fault == (deny_valid && $past(ctrl_q[0]))));

  assert_fault_needs_deny_R8: assert property (@(posedge clk) disable iff (rst)
    fault |-> deny_valid);
endmodule

bind blk_sec_gate blk_sec_gate_chk chk_i (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .acc_valid(acc_valid), .acc_nsec(acc_nsec), .ctrl_q(ctrl_q),
  .fwd_valid(fwd_valid), .deny_valid(deny_valid), .deny_err(deny_err), .fault(fault)
);

// File: tb/blk_sec_gate_tb_top.sv
module blk_sec_gate_tb_top;
  localparam int SZ    = 1;
  localparam int CNT   = 6;
  localparam int OFS_W = 16;
  localparam int BLK_BYTES = 1 << (SZ + 5);
  localparam int NBLK      = 1 << CNT;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic acc_valid = 0, acc_write = 0, acc_nsec = 0;
  logic [OFS_W-1:0] acc_ofs = 0, fwd_ofs;
  logic [31:0] acc_wdata = 0, fwd_wdata;
  logic fwd_valid, fwd_write, fwd_nsec, deny_valid, deny_err, fault;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  blk_sec_gate #(.SIZE_CODE(SZ), .COUNT_CODE(CNT), .OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_ofs(acc_ofs), .acc_write(acc_write), .acc_nsec(acc_nsec),
    .acc_wdata(acc_wdata), .fwd_valid(fwd_valid), .fwd_ofs(fwd_ofs),
    .fwd_write(fwd_write), .fwd_nsec(fwd_nsec), .fwd_wdata(fwd_wdata),
    .deny_valid(deny_valid), .deny_err(deny_err), .fault(fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit stripe(input int i);
    return ((i * 7 + 3) % 5) < 2;
  endfunction

  function automatic logic [31:0] stripe_word(input int w);
    logic [31:0] v;
    for (int b = 0; b < 32; b++) v[b] = stripe(w * 32 + b);
    return v;
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic access(input int ofs, input bit ns, input bit wr, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_ofs = OFS_W'(ofs); acc_nsec = ns; acc_write = wr; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 fwd_valid", 32'(fwd_valid), 0);
    chk("R1 deny_valid", 32'(deny_valid), 0);
    chk("R1 fault", 32'(fault), 0);
    rd_reg(8'h00, d); chk("R1 ctrl", d, 0);
    for (int w = 0; w < 2; w++) begin
      rd_reg(8'(16 + 4 * w), d); chk("R1 table word", d, 0);
    end
    // R2 configuration word, read-only
    rd_reg(8'h04, d); chk("R2 cfg", d, 32'h8000_0000 | (CNT << 8) | SZ);
    wr_reg(8'h04, 32'h1234_5678);
    rd_reg(8'h04, d); chk("R2 cfg after write", d, 32'h8000_0000 | (CNT << 8) | SZ);
    // R3 control
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, d); chk("R3 ctrl all ones", d, 3);
    wr_reg(8'h00, 32'h0000_0002);
    rd_reg(8'h00, d); chk("R3 ctrl=2", d, 2);
    wr_reg(8'h00, 0);
    // R10 reserved and out-of-range offsets
    wr_reg(8'h08, 32'hFFFF_FFFF); rd_reg(8'h08, d); chk("R10 reserved 0x08", d, 0);
    wr_reg(8'h0C, 32'hA5A5_A5A5); rd_reg(8'h0C, d); chk("R10 reserved 0x0C", d, 0);
    wr_reg(8'h48, 32'hFFFF_FFFF); rd_reg(8'h48, d); chk("R10 offset 0x48", d, 0);
    // R9 table word beyond block count
    wr_reg(8'h18, 32'hFFFF_FFFF); rd_reg(8'h18, d); chk("R9 word beyond count", d, 0);
    // R4 table readback with stripe pattern
    for (int w = 0; w < 2; w++) wr_reg(8'(16 + 4 * w), stripe_word(w));
    for (int w = 0; w < 2; w++) begin
      rd_reg(8'(16 + 4 * w), d); chk("R4 table readback", d, stripe_word(w));
    end
    // R5/R6 sweep of every block at first and last byte, both attributes
    for (int i = 0; i < NBLK + 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        for (int ns = 0; ns < 2; ns++) begin
          int ofs;
          bit allow;
          ofs = i * BLK_BYTES + e * (BLK_BYTES - 1);
          allow = (ns == 0) || (i < NBLK && stripe(i));
          access(ofs, ns[0], e[0], 32'(ofs * 3 + 1));
          if (i < NBLK) begin
            chk("R5 R6 forward", 32'(fwd_valid), 32'(allow));
            chk("R5 R6 deny", 32'(deny_valid), 32'(!allow));
          end else begin
            chk("R9 beyond count forward", 32'(fwd_valid), 32'(allow));
            chk("R9 beyond count deny", 32'(deny_valid), 32'(!allow));
          end
          if (allow) begin
            chk("R6 pass ofs", 32'(fwd_ofs), 32'(ofs));
            chk("R6 pass dir", 32'(fwd_write), 32'(e));
            chk("R6 pass attr", 32'(fwd_nsec), 32'(ns));
            chk("R6 pass data", fwd_wdata, 32'(ofs * 3 + 1));
          end
        end
      end
    end
    // R7/R8 response modes on a secure block (block 0 stripe bit = 0)
    for (int c = 0; c < 4; c++) begin
      wr_reg(8'h00, 32'(c));
      for (int wr = 0; wr < 2; wr++) begin
        access(5, 1'b1, wr[0], 32'hDEAD_BEEF);
        chk("R7 denied", 32'(deny_valid), 1);
        chk("R7 dropped", 32'(fwd_valid), 0);
        chk("R7 deny_err", 32'(deny_err), 32'(c >> 1));
        chk("R8 fault", 32'(fault), 32'(c & 1));
        @(negedge clk);
        chk("R8 fault one cycle", 32'(fault), 0);
        chk("R7 deny one cycle", 32'(deny_valid), 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule